// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves a data word between two ports, A and B, in either direction. Each direction owns a storage register with its own clock. The A-side register samples port A on the A-to-B clock, and the B-side register samples port B on the B-to-A clock. An active-low output enable and a direction input together decide which port, if any, is driven. A per-direction select input decides whether the driven port carries the live word from the opposite port or the word held in that direction's register.

Each port is modelled as three signals: an input bus, an output bus and an output-enable flag. There is no tristate pin. A surrounding pad ring or bus fabric merges them. An output bus whose flag is low reads all zeros.

Both registers keep sampling on their clocks whatever the enable, direction and select inputs are set to. A word can therefore be captured while the ports are isolated and presented later in stored mode.

Top module: `regbus_xcvr`

## Requirements
- R1: While `oe_n` is 1, both `a_oe` and `b_oe` are 0. Any output bus whose enable flag is 0 reads all zeros.
- R2: `a_oe` and `b_oe` are never both 1. With `oe_n`=0, `dir_a2b`=1 gives `b_oe`=1 and `a_oe`=0, and `dir_a2b`=0 gives `a_oe`=1 and `b_oe`=0.
- R3: On every rising edge of `clk_a2b` with `rst`=0, the A-side register takes `a_in`. This happens regardless of `oe_n`, `dir_a2b` and both selects.
- R4: On every rising edge of `clk_b2a` with `rst`=0, the B-side register takes `b_in`. This happens regardless of `oe_n`, `dir_a2b` and both selects.
- R5: With `b_oe`=1 and `hold_a2b`=0, `b_out` equals `a_in` combinationally (transparent mode). `hold_b2a` has no effect on it.
- R6: With `b_oe`=1 and `hold_a2b`=1, `b_out` equals the A-side register. After a `clk_a2b` rising edge, the newly captured word appears on `b_out`.
- R7: With `a_oe`=1 and `hold_b2a`=0, `a_out` equals `b_in` combinationally. `hold_a2b` has no effect on it.
- R8: With `a_oe`=1 and `hold_b2a`=1, `a_out` equals the B-side register. After a `clk_b2a` rising edge, the newly captured word appears on `a_out`.
- R9: A rising edge of `clk_a2b` with `rst`=1 clears the A-side register to zero. A rising edge of `clk_b2a` with `rst`=1 clears the B-side register to zero. `rst` has no effect on `a_oe` or `b_oe`.
- R10: The input bus of the port being driven never reaches the driven output. With `dir_a2b`=1, changing `b_in` leaves `b_out` unchanged. With `dir_a2b`=0, changing `a_in` leaves `a_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a2b | input | 1 | Capture clock of the A-side register |
| clk_b2a | input | 1 | Capture clock of the B-side register |
| rst | input | 1 | Synchronous active-high clear, applied on each register's own clock |
| oe_n | input | 1 | Active-low output enable for both ports |
| dir_a2b | input | 1 | 1 drives port B from the A side; 0 drives port A from the B side |
| hold_a2b | input | 1 | 1 selects the A-side register for port B; 0 selects live `a_in` |
| hold_b2a | input | 1 | 1 selects the B-side register for port A; 0 selects live `b_in` |
| a_in | input | W | Word present on port A |
| a_out | output | W | Word driven onto port A |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | W | Word present on port B |
| b_out | output | W | Word driven onto port B |
| b_oe | output | 1 | Port B drive enable |

## Verification
The bench captures words while both ports are isolated and then shows them in stored mode. A design that gated capture on the enable would present stale register contents. It flips the select of the inactive direction, which would expose a mux steered by the wrong select, and it wiggles the input bus of the port being driven to catch a transparent path wired back onto itself. It also clocks a register in stored mode to confirm that the new word appears on the far port after the edge, and it holds reset across both clocks. A reset that leaked into the enable logic would drop the drive flags during that reset.

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W = 8
) (
  input  logic         clk_a2b,
  input  logic         clk_b2a,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir_a2b,
  input  logic         hold_a2b,
  input  logic         hold_b2a,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] reg_a;
  logic [W-1:0] reg_b;
  logic [W-1:0] pick_b;
  logic [W-1:0] pick_a;

  always_ff @(posedge clk_a2b) begin
    if (rst) reg_a <= ZERO;
    else     reg_a <= a_in;
  end

  always_ff @(posedge clk_b2a) begin
    if (rst) reg_b <= ZERO;
    else     reg_b <= b_in;
  end

  assign b_oe   = !oe_n &&  dir_a2b;
  assign a_oe   = !oe_n && !dir_a2b;
  assign pick_b = hold_a2b ? reg_a : a_in;
  assign pick_a = hold_b2a ? reg_b : b_in;
  assign b_out  = b_oe ? pick_b : ZERO;
  assign a_out  = a_oe ? pick_a : ZERO;

  always_comb begin
    a_r2_one_driver: assert (!(a_oe && b_oe));
    a_r1_isolated: assert (!oe_n || (!a_oe && !b_oe && a_out == ZERO && b_out == ZERO));
  end

  a_r3_capture_a: assert property (@(posedge clk_a2b) disable iff (rst)
    1'b1 |=> reg_a == $past(a_in));

  a_r4_capture_b: assert property (@(posedge clk_b2a) disable iff (rst)
    1'b1 |=> reg_b == $past(b_in));

  a_r6_stored_a2b: assert property (@(posedge clk_a2b) disable iff (rst)
    1'b1 |=> (!(b_oe && hold_a2b) || b_out == $past(a_in)));

  a_r8_stored_b2a: assert property (@(posedge clk_b2a) disable iff (rst)
    1'b1 |=> (!(a_oe && hold_b2a) || a_out == $past(b_in)));

  a_r9_clear_a: assert property (@(posedge clk_a2b)
    rst |=> reg_a == ZERO);

  a_r9_clear_b: assert property (@(posedge clk_b2a)
    rst |=> reg_b == ZERO);

endmodule

// File: tb/sim_regbus_xcvr.sv
module sim_regbus_xcvr;
  localparam int W = 8;
  localparam int NV = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic clk_a2b = 1'b0, clk_b2a = 1'b0, rst = 1'b1;
  logic oe_n = 1'b1, dir_a2b = 1'b0, hold_a2b = 1'b0, hold_b2a = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  regbus_xcvr #(.W(W)) u0 (
    .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .rst(rst), .oe_n(oe_n),
    .dir_a2b(dir_a2b), .hold_a2b(hold_a2b), .hold_b2a(hold_b2a),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // {oe_n, dir, hold_a2b, hold_b2a, a_in, b_in, exp a_oe, exp b_oe, exp a_out, exp b_out}
  // registers preloaded: A side 8'h3C, B side 8'hC5
  localparam logic [37:0] VEC [NV] = '{
    {4'b1100, 8'h11, 8'h22, 2'b00, 8'h00, 8'h00},
    {4'b1011, 8'h11, 8'h22, 2'b00, 8'h00, 8'h00},
    {4'b0100, 8'h5A, 8'hA5, 2'b01, 8'h00, 8'h5A},
    {4'b0100, 8'hFF, 8'h00, 2'b01, 8'h00, 8'hFF},
    {4'b0110, 8'h5A, 8'hA5, 2'b01, 8'h00, 8'h3C},
    {4'b0000, 8'h5A, 8'hA5, 2'b10, 8'hA5, 8'h00},
    {4'b0000, 8'h00, 8'h81, 2'b10, 8'h81, 8'h00},
    {4'b0001, 8'h00, 8'h81, 2'b10, 8'hC5, 8'h00},
    {4'b0101, 8'h77, 8'h12, 2'b01, 8'h00, 8'h77},
    {4'b0010, 8'h77, 8'h12, 2'b10, 8'h12, 8'h00}
  };
  localparam string TAG [NV] = '{"R1", "R1", "R5", "R5", "R6",
                                 "R7", "R7", "R8", "R5", "R7"};

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pulse_a;
    @(negedge clk) clk_a2b = 1'b1;
    @(negedge clk) clk_a2b = 1'b0;
    #2;
  endtask

  task automatic pulse_b;
    @(negedge clk) clk_b2a = 1'b1;
    @(negedge clk) clk_b2a = 1'b0;
    #2;
  endtask

  task automatic setv(input logic o, input logic d, input logic ha, input logic hb,
                      input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    oe_n = o; dir_a2b = d; hold_a2b = ha; hold_b2a = hb; a_in = a; b_in = b;
    #2;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: reset clears both registers; enable flags follow oe_n/dir during reset
    setv(1'b0, 1'b1, 1'b1, 1'b1, 8'hAA, 8'h55);
    pulse_a();
    pulse_b();
    check("R9", "b_oe during reset", {7'd0, b_oe}, 8'h01);
    check("R9", "b_out stored after reset", b_out, 8'h00);
    setv(1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h55);
    check("R9", "a_oe during reset", {7'd0, a_oe}, 8'h01);
    check("R9", "a_out stored after reset", a_out, 8'h00);
    @(negedge clk) rst = 1'b0;

    // R3 R4: preload registers while isolated
    setv(1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hC5);
    pulse_a();
    pulse_b();
    check("R1", "a_out isolated", a_out, 8'h00);
    check("R1", "b_out isolated", b_out, 8'h00);

    for (int i = 0; i < NV; i++) begin
      setv(VEC[i][37], VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:26], VEC[i][25:18]);
      check("R2", "a_oe", {7'd0, a_oe}, {7'd0, VEC[i][17]});
      check("R2", "b_oe", {7'd0, b_oe}, {7'd0, VEC[i][16]});
      check(TAG[i], "a_out", a_out, VEC[i][15:8]);
      check(TAG[i], "b_out", b_out, VEC[i][7:0]);
    end

    // R3: capture while direction drives A and selects are mixed
    setv(1'b0, 1'b0, 1'b0, 1'b1, 8'h9E, 8'h00);
    pulse_a();
    setv(1'b0, 1'b1, 1'b1, 1'b0, 8'h01, 8'h00);
    check("R3", "A register via b_out", b_out, 8'h9E);

    // R4: capture while direction drives B
    setv(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h6D);
    pulse_b();
    setv(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h02);
    check("R4", "B register via a_out", a_out, 8'h6D);

    // R6: clocking in stored mode shows new word on B after edge
    setv(1'b0, 1'b1, 1'b1, 1'b0, 8'hE7, 8'h00);
    check("R6", "b_out before edge", b_out, 8'h9E);
    pulse_a();
    check("R6", "b_out after edge", b_out, 8'hE7);

    // R8: same for the B-side register onto A
    setv(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h4B);
    check("R8", "a_out before edge", a_out, 8'h6D);
    pulse_b();
    check("R8", "a_out after edge", a_out, 8'h4B);

    // R10: driven port's own input bus is ignored
    setv(1'b0, 1'b1, 1'b0, 1'b0, 8'h3A, 8'h00);
    setv(1'b0, 1'b1, 1'b0, 1'b0, 8'h3A, 8'hFF);
    check("R10", "b_out ignores b_in", b_out, 8'h3A);
    setv(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC3);
    setv(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hC3);
    check("R10", "a_out ignores a_in", a_out, 8'hC3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule